// File: doc/BRIEF.md
# Nine-bit multiprocessor UART

This block is a full-duplex asynchronous serial port. Each frame carries eight data bits plus a ninth bit that software chooses. Software talks to it over a small register bus. Writing a byte to the data register sends a frame. The ninth bit comes from a control field, so it can carry parity or mark a frame as an address in a multi-drop network.

The receiver listens only while its enable bit is set. It samples the line 16 times per bit and takes a majority vote of three samples at each bit centre. At the end of a frame it applies an address filter before it loads anything. A frame is taken only if the previous byte has been consumed. With the filter enabled, the received ninth bit must also be 1. The bit clock comes from one of two sources: a fixed divide of the system clock with a speed-doubling option, or an external tick input. Flags for transmit-done and receive-full drive a single interrupt output, which has its own enable.

Top module: `mpuart9`

## Requirements
- R1: The line idles high. A frame is a 0 start bit, then data bits 0 through 7 in that order, then the ninth bit, then a 1 stop bit. The ninth bit equals control bit 3 (tx ninth) at the time the byte is written.
- R2: A write to address 0 while the transmitter is idle starts a frame. A write to address 0 while a frame is in progress is dropped: the current frame is unchanged and no second frame follows.
- R3: The transmit-done flag (control bit 0) becomes 1 at the start of the stop bit. It is already 1 at the middle of the stop bit and still 0 at the middle of the ninth bit.
- R4: With control bit 6 (external rate) at 0, one bit lasts BASE_DIV clocks when aux bit 0 (double speed) is 0, and BASE_DIV/2 clocks when it is 1. Aux bit 0 resets to 0.
- R5: With control bit 6 at 1, one bit lasts 16 pulses of `ext_tick`.
- R6: While control bit 4 (receive enable) is 0, a frame on `rxd` loads nothing and leaves the receive flag at 0.
- R7: When a frame ends with the receive flag (control bit 1) at 0 and the filter (control bit 5) at 0, the byte goes to the register read at address 0, the ninth bit goes to control bit 2, and the receive flag is set.
- R8: While the receive flag is 1, a new frame loads nothing. The receive buffer and control bit 2 keep their old values.
- R9: With the filter at 1, a frame whose ninth bit is 0 is discarded. A frame whose ninth bit is 1 is loaded.
- R10: The value of the received stop bit has no effect. A frame with a 0 stop bit loads like any other frame.
- R11: A low pulse on `rxd` shorter than half a bit is rejected as a false start. It loads nothing, and the receiver is ready for the next frame.
- R12: A glitch lasting one oversample period near a data bit centre does not change the received value.
- R13: `irq` is 1 exactly when aux bit 1 (interrupt enable) is 1 and either flag is set. A flag is cleared only by writing 0 to its control bit. Writing 1 leaves it unchanged.
- R14: After reset, `txd` is 1, `irq` is 0, and the data, control and aux registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control, 2 aux |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| rxd | input | 1 | Serial receive line |
| ext_tick | input | 1 | External oversample tick, one clock wide |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets the following corner cases:
- **Timing of the transmit-done flag.** It reads the flag at the middle of the ninth bit and again at the middle of the stop bit. A design that raises the flag at the end of the frame fails the second read.
- **Data-register write during a frame.** It writes the data register in the middle of a frame. A design that reloads the shifter would corrupt the frame on the line or send an extra frame.
- **Receive gating.** It sends frames with the receive flag already set, with the filter on and a zero ninth bit, with a zero stop bit, and with reception disabled. A design that gates loading wrongly either overwrites the buffer or drops a valid byte.
- **Line noise.** It injects a short false start and a one-sample glitch in a data bit. A receiver without confirmation or majority voting would load garbage or get stuck mid-frame.

// File: rtl/mpuart9_pkg.sv
package mpuart9_pkg;

    localparam int OSR        = 16;
    localparam int OSR_W      = $clog2(OSR);
    localparam int FRAME_BITS = 11;
    localparam int PAYLOAD    = 9;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_AUX  = 2'd2;

    localparam int C_TI    = 0;
    localparam int C_RI    = 1;
    localparam int C_RB8   = 2;
    localparam int C_TB8   = 3;
    localparam int C_REN   = 4;
    localparam int C_FILT  = 5;
    localparam int C_EXT   = 6;
    localparam int X_FAST  = 0;
    localparam int X_IRQEN = 1;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_e;

    typedef struct packed {
        logic       ninth;
        logic [7:0] data;
    } word9_t;

    typedef struct packed {
        logic ext_rate;
        logic filt;
        logic rx_en;
        logic tb8;
    } ctrl_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/mpuart9_baud.sv
module mpuart9_baud #(
    parameter int PRE_SLOW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fast,
    input  logic ext_rate,
    input  logic ext_tick,
    output logic os_tick
);
    localparam int PRE_FAST = PRE_SLOW / 2;
    localparam int CW       = $clog2(PRE_SLOW) + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          div_tick;

    assign lim = fast ? CW'(PRE_FAST - 1) : CW'(PRE_SLOW - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            div_tick <= 1'b0;
        end else if (cnt >= lim) begin
            cnt      <= '0;
            div_tick <= 1'b1;
        end else begin
            cnt      <= cnt + 1'b1;
            div_tick <= 1'b0;
        end
    end

    assign os_tick = ext_rate ? ext_tick : div_tick;
endmodule

// File: rtl/mpuart9_tx.sv
module mpuart9_tx
    import mpuart9_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   os_tick,
    input  logic   load,
    input  word9_t word,
    output logic   txd,
    output logic   busy,
    output logic   stop_pulse
);
    logic [FRAME_BITS-1:0] sh;
    logic [OSR_W-1:0]      phase;
    logic [3:0]            idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh         <= '1;
            busy       <= 1'b0;
            phase      <= '0;
            idx        <= '0;
            stop_pulse <= 1'b0;
        end else begin
            stop_pulse <= 1'b0;
            if (!busy) begin
                if (load) begin
                    sh    <= {1'b1, word.ninth, word.data, 1'b0};
                    busy  <= 1'b1;
                    phase <= '0;
                    idx   <= '0;
                end
            end else if (os_tick) begin
                if (phase == OSR_W'(OSR - 1)) begin
                    phase <= '0;
                    if (idx == 4'(FRAME_BITS - 1)) begin
                        busy <= 1'b0;
                        sh   <= '1;
                    end else begin
                        sh         <= {1'b1, sh[FRAME_BITS-1:1]};
                        idx        <= idx + 1'b1;
                        stop_pulse <= (idx == 4'(FRAME_BITS - 2));
                    end
                end else begin
                    phase <= phase + 1'b1;
                end
            end
        end
    end

    assign txd = sh[0];
endmodule

// File: rtl/mpuart9_rx.sv
module mpuart9_rx
    import mpuart9_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   os_tick,
    input  logic   rx_en,
    input  logic   rxd,
    output logic   done,
    output word9_t word
);
    localparam logic [OSR_W-1:0] MID = OSR_W'(OSR / 2 + 1);

    logic [SYNC-1:0]    sync;
    logic               rx_s;
    logic               last_s;
    logic [1:0]         hist;
    rx_state_e          st;
    logic [OSR_W-1:0]   phase;
    logic [3:0]         cnt;
    logic [PAYLOAD-1:0] sh;
    logic               v;
    logic               mid;

    assign rx_s = sync[SYNC-1];
    assign v    = vote3({hist, rx_s});
    assign mid  = (phase == MID);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync   <= '1;
            last_s <= 1'b1;
            hist   <= 2'b11;
            st     <= RX_IDLE;
            phase  <= '0;
            cnt    <= '0;
            sh     <= '0;
            done   <= 1'b0;
            word   <= '0;
        end else begin
            sync <= {sync[SYNC-2:0], rxd};
            done <= 1'b0;
            if (os_tick) begin
                hist   <= {hist[0], rx_s};
                last_s <= rx_s;
                phase  <= phase + 1'b1;
                unique case (st)
                    RX_IDLE: begin
                        if (rx_en && last_s && !rx_s) begin
                            st    <= RX_START;
                            phase <= OSR_W'(1);
                        end
                    end
                    RX_START: begin
                        if (mid) begin
                            if (v) st <= RX_IDLE;
                            else begin
                                st  <= RX_BITS;
                                cnt <= '0;
                            end
                        end
                    end
                    RX_BITS: begin
                        if (mid) begin
                            sh <= {v, sh[PAYLOAD-1:1]};
                            if (cnt == 4'(PAYLOAD - 1)) st <= RX_STOP;
                            else cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (mid) begin
                            st   <= RX_IDLE;
                            done <= 1'b1;
                            word <= word9_t'(sh);
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mpuart9.sv
module mpuart9
    import mpuart9_pkg::*;
#(
    parameter int BASE_DIV    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxd,
    input  logic       ext_tick,
    output logic       txd,
    output logic       irq
);
    localparam int PRE_SLOW = BASE_DIV / OSR;

    ctrl_t      ctrl;
    logic       ti, ri, rb8, fast, irq_en;
    logic [7:0] rbuf;
    logic       os_tick, tx_busy, tx_stop, rx_done, accept;
    logic       wr_data, wr_ctrl, wr_aux;
    word9_t     rword;

    assign wr_data = bus_we && (bus_addr == A_DATA);
    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
    assign wr_aux  = bus_we && (bus_addr == A_AUX);

    mpuart9_baud #(.PRE_SLOW(PRE_SLOW)) u_baud (
        .clk(clk), .rst(rst), .fast(fast), .ext_rate(ctrl.ext_rate),
        .ext_tick(ext_tick), .os_tick(os_tick)
    );

    mpuart9_tx u_tx (
        .clk(clk), .rst(rst), .os_tick(os_tick), .load(wr_data),
        .word('{ninth: ctrl.tb8, data: bus_wdata}),
        .txd(txd), .busy(tx_busy), .stop_pulse(tx_stop)
    );

    mpuart9_rx #(.SYNC(SYNC_STAGES)) u_rx (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rx_en(ctrl.rx_en),
        .rxd(rxd), .done(rx_done), .word(rword)
    );

    assign accept = rx_done && !ri && (!ctrl.filt || rword.ninth);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            ti     <= 1'b0;
            ri     <= 1'b0;
            rb8    <= 1'b0;
            rbuf   <= '0;
            fast   <= 1'b0;
            irq_en <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl <= '{ext_rate: bus_wdata[C_EXT], filt: bus_wdata[C_FILT],
                          rx_en: bus_wdata[C_REN], tb8: bus_wdata[C_TB8]};
            end
            if (wr_aux) begin
                fast   <= bus_wdata[X_FAST];
                irq_en <= bus_wdata[X_IRQEN];
            end
            if (tx_stop) ti <= 1'b1;
            else if (wr_ctrl && !bus_wdata[C_TI]) ti <= 1'b0;
            if (accept) begin
                ri   <= 1'b1;
                rbuf <= rword.data;
                rb8  <= rword.ninth;
            end else if (wr_ctrl && !bus_wdata[C_RI]) begin
                ri <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_DATA:  bus_rdata = rbuf;
            A_CTRL:  bus_rdata = {1'b0, ctrl.ext_rate, ctrl.filt, ctrl.rx_en,
                                  ctrl.tb8, rb8, ri, ti};
            A_AUX:   bus_rdata = {6'b0, irq_en, fast};
            default: bus_rdata = 8'h00;
        endcase
    end

    assign irq = irq_en & (ti | ri);
endmodule

// File: rtl/mpuart9_chk.sv
module mpuart9_chk (
    input logic       clk,
    input logic       rst,
    input logic       txd,
    input logic       ti,
    input logic       ri,
    input logic       tx_busy,
    input logic       tx_stop,
    input logic       rx_done,
    input logic       bus_we,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata
);
    p_idle_line_high_r1: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd);

    p_start_bit_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> !txd);

    p_ti_from_stop_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ti) |-> $past(tx_stop));

    p_ti_in_stop_bit_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ti) |-> (txd && tx_busy));

    p_ri_from_frame_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ri) |-> $past(rx_done));

    p_ri_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        (ri && !(bus_we && bus_addr == 2'd1 && !bus_wdata[1])) |=> ri);

    p_ti_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        (ti && !(bus_we && bus_addr == 2'd1 && !bus_wdata[0])) |=> ti);
endmodule

bind mpuart9 mpuart9_chk u_chk (
    .clk(clk), .rst(rst), .txd(txd), .ti(ti), .ri(ri), .tx_busy(tx_busy),
    .tx_stop(tx_stop), .rx_done(rx_done), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/tb_mpuart9.sv
`timescale 1ns/1ps
module tb_mpuart9;
    localparam int BIT = 64;
    localparam int P   = BIT / 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       ext_tick = 1'b0;
    logic       txd, irq;
    int         ecnt = 0;
    int         n_chk = 0;
    int         n_fail = 0;

    mpuart9 dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd),
        .ext_tick(ext_tick), .txd(txd), .irq(irq)
    );

    always #2 clk = ~clk;

    always @(negedge clk) begin
        ecnt     <= (ecnt == 2) ? 0 : ecnt + 1;
        ext_tick <= (ecnt == 2);
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] cw(bit ext, bit filt, bit ren, bit tb8,
                                      bit keep_ri, bit keep_ti);
        return {1'b0, ext, filt, ren, tb8, 1'b0, keep_ri, keep_ti};
    endfunction

    function automatic bit rx_loads(bit ri_prev, bit filt, bit b9);
        return !ri_prev && (!filt || b9);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cap_tx(input int p, output logic [7:0] d, output logic b9,
                          output logic stb, output logic stp,
                          output logic ti9, output logic ti10);
        int t = 0;
        logic [10:0] bits;
        @(negedge clk);
        while (txd) @(negedge clk);
        for (int i = 0; i < 11; i++) begin
            while (t < 16*p*i + 7*p) begin @(negedge clk); t++; end
            bits[i] = txd;
            if (i == 9)  ti9  = bus_rdata[0];
            if (i == 10) ti10 = bus_rdata[0];
        end
        d = bits[8:1]; b9 = bits[9]; stb = bits[0]; stp = bits[10];
        repeat (10*p) @(negedge clk);
    endtask

    task automatic tx_frame(input int p, input bit ext, input logic [7:0] d, input bit b9);
        logic [7:0] gd; logic gb, stb, stp, ti9, ti10;
        wr(2'd1, cw(ext, 0, 0, b9, 1, 0));
        wr(2'd0, d);
        bus_addr = 2'd1;
        cap_tx(p, gd, gb, stb, stp, ti9, ti10);
        chk("R1", "start bit", {31'd0, stb}, 0);
        chk("R1", "data", {24'd0, gd}, {24'd0, d});
        chk("R1", "ninth bit", {31'd0, gb}, {31'd0, b9});
        chk("R1", "stop bit", {31'd0, stp}, 1);
        chk("R3", "ti at ninth bit", {31'd0, ti9}, 0);
        chk("R3", "ti at stop bit", {31'd0, ti10}, 1);
    endtask

    task automatic measure(input int p, input string req, input int exp);
        int n = 0;
        wr(2'd0, 8'h01);
        @(negedge clk);
        while (!txd) @(negedge clk);
        while (txd) begin @(negedge clk); n++; end
        chk(req, "bit length", n, exp);
        repeat (200*p) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] d, input bit b9, input bit stp, input int gbit);
        logic [10:0] f;
        f = {stp, b9, d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            rxd = f[i];
            if (i == gbit) begin
                repeat (BIT/2 - 2) @(negedge clk);
                rxd = ~f[i];
                repeat (P) @(negedge clk);
                rxd = f[i];
                repeat (BIT/2 - 2) @(negedge clk);
            end else begin
                repeat (BIT) @(negedge clk);
            end
        end
        rxd = 1'b1;
        repeat (2*BIT) @(negedge clk);
    endtask

    task automatic rx_expect(input string req, input bit ri_e, input bit rb8_e,
                             input logic [7:0] buf_e);
        logic [7:0] c, b;
        rd(2'd1, c);
        rd(2'd0, b);
        chk(req, "receive flag", {31'd0, c[1]}, {31'd0, ri_e});
        chk(req, "rx ninth", {31'd0, c[2]}, {31'd0, rb8_e});
        chk(req, "rx buffer", {24'd0, b}, {24'd0, buf_e});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v, d, gd;
        logic gb, stb, stp, ti9, ti10;
        bit b9, filt, clr, ri_m, rb8_m;
        logic [7:0] rbuf_m;
        int hi;
        void'($urandom(32'h1f2e3d4c));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R14", "txd after reset", {31'd0, txd}, 1);
        chk("R14", "irq after reset", {31'd0, irq}, 0);
        rd(2'd1, v); chk("R14", "control after reset", {24'd0, v}, 0);
        rd(2'd2, v); chk("R4", "aux after reset (slow rate)", {24'd0, v}, 0);
        rd(2'd0, v); chk("R14", "data after reset", {24'd0, v}, 0);

        // R1 R3: random frames at the fixed slow rate
        for (int k = 0; k < 4; k++) begin
            d = 8'($urandom); b9 = 1'($urandom);
            tx_frame(P, 0, d, b9);
        end
        tx_frame(P, 0, 8'h00, 1'b1);
        tx_frame(P, 0, 8'hff, 1'b0);

        // R2: write during a frame is dropped
        wr(2'd1, cw(0, 0, 0, 1, 1, 0));
        wr(2'd0, 8'hc3);
        bus_addr = 2'd1;
        fork
            cap_tx(P, gd, gb, stb, stp, ti9, ti10);
            begin repeat (5*BIT) @(negedge clk); wr(2'd0, 8'h3c); end
        join
        chk("R2", "frame kept during busy write", {23'd0, gb, gd}, {23'd0, 1'b1, 8'hc3});
        hi = 1;
        for (int i = 0; i < 3*BIT; i++) begin @(negedge clk); if (!txd) hi = 0; end
        chk("R2", "no second frame", hi, 1);

        // R4: bit length slow and fast; R5: external tick
        wr(2'd1, cw(0, 0, 0, 0, 1, 1));
        measure(P, "R4", BIT);
        wr(2'd2, 8'h01);
        measure(P/2, "R4", BIT/2);
        tx_frame(P/2, 0, 8'($urandom), 1'($urandom));
        wr(2'd2, 8'h00);
        wr(2'd1, cw(1, 0, 0, 0, 1, 1));
        measure(3, "R5", 48);
        tx_frame(3, 1, 8'($urandom), 1'($urandom));
        wr(2'd1, cw(0, 0, 0, 0, 1, 1));

        // R7 R8 R9: random receive traffic against a model
        wr(2'd1, cw(0, 0, 1, 0, 0, 0));
        ri_m = 0; rb8_m = 0; rbuf_m = 8'h00;
        for (int k = 0; k < 10; k++) begin
            d = 8'($urandom); b9 = 1'($urandom); filt = 1'($urandom); clr = 1'($urandom);
            wr(2'd1, cw(0, filt, 1, 0, !clr, 1));
            if (clr) ri_m = 0;
            if (rx_loads(ri_m, filt, b9)) begin ri_m = 1; rb8_m = b9; rbuf_m = d; end
            send_rx(d, b9, 1, -1);
            rx_expect(ri_m ? "R7" : "R9", ri_m, rb8_m, rbuf_m);
        end

        // R7 directed, then R8 flag held
        wr(2'd1, cw(0, 0, 1, 0, 0, 0));
        send_rx(8'h5a, 1, 1, -1);
        rx_expect("R7", 1, 1, 8'h5a);
        send_rx(8'ha5, 0, 1, -1);
        rx_expect("R8", 1, 1, 8'h5a);

        // R9 filter directed
        wr(2'd1, cw(0, 1, 1, 0, 0, 0));
        send_rx(8'h11, 0, 1, -1);
        rx_expect("R9", 0, 1, 8'h5a);
        send_rx(8'h22, 1, 1, -1);
        rx_expect("R9", 1, 1, 8'h22);

        // R10 zero stop bit
        wr(2'd1, cw(0, 0, 1, 0, 0, 0));
        send_rx(8'h3b, 0, 0, -1);
        rx_expect("R10", 1, 0, 8'h3b);

        // R6 receiver disabled
        wr(2'd1, cw(0, 0, 0, 0, 0, 0));
        send_rx(8'h77, 1, 1, -1);
        rx_expect("R6", 0, 0, 8'h3b);

        // R11 false start, then a good frame
        wr(2'd1, cw(0, 0, 1, 0, 0, 0));
        rxd = 1'b0; repeat (3*P) @(negedge clk); rxd = 1'b1;
        repeat (3*BIT) @(negedge clk);
        rx_expect("R11", 0, 0, 8'h3b);
        send_rx(8'h96, 1, 1, -1);
        rx_expect("R11", 1, 1, 8'h96);

        // R12 glitch at data bit centres
        wr(2'd1, cw(0, 0, 1, 0, 0, 0));
        send_rx(8'hc6, 0, 1, 4);
        rx_expect("R12", 1, 0, 8'hc6);
        wr(2'd1, cw(0, 0, 1, 0, 0, 0));
        send_rx(8'h39, 1, 1, 9);
        rx_expect("R12", 1, 1, 8'h39);

        // R13 interrupt and sticky flags
        wr(2'd1, cw(0, 0, 1, 0, 0, 0));
        wr(2'd2, 8'h02);
        @(negedge clk); chk("R13", "irq no flags", {31'd0, irq}, 0);
        send_rx(8'h44, 0, 1, -1);
        chk("R13", "irq on rx flag", {31'd0, irq}, 1);
        wr(2'd1, cw(0, 0, 1, 0, 1, 1));
        @(negedge clk); chk("R13", "irq after writing ones", {31'd0, irq}, 1);
        rd(2'd1, v); chk("R13", "rx flag after writing one", {31'd0, v[1]}, 1);
        wr(2'd2, 8'h00);
        @(negedge clk); chk("R13", "irq masked", {31'd0, irq}, 0);
        wr(2'd2, 8'h02);
        @(negedge clk); chk("R13", "irq unmasked", {31'd0, irq}, 1);
        wr(2'd1, cw(0, 0, 1, 0, 0, 1));
        @(negedge clk); chk("R13", "irq after rx clear", {31'd0, irq}, 0);
        wr(2'd0, 8'h81);
        repeat (11*BIT) @(negedge clk);
        chk("R13", "irq on tx flag", {31'd0, irq}, 1);
        wr(2'd1, cw(0, 0, 1, 0, 1, 0));
        @(negedge clk); chk("R13", "irq after tx clear", {31'd0, irq}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule